// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block collects interrupt requests for a single processor, ranks them by a per-ID priority and raises one request line toward the core whenever the most urgent eligible interrupt beats both a software-programmed priority threshold and the priority of whatever the core is already servicing. Each ID carries enable, pending and active state, a 4-bit significant priority and a trigger-mode bit. The upper part of the ID space (IDs 32 and above by default) is wired to peripheral request inputs. The lower IDs can only be made pending by software.

Software talks to the block over a simple 32-bit register bus. Enable and pending state are changed through separate set and clear banks, so a write never needs a read-modify-write. The interrupt service sequence has three steps. A read of the acknowledge register returns the winning ID and marks it active. The handler runs. A write of the ID to the end-of-interrupt register retires it. A query register reports the same winner without any side effect. ID 1023 means that nothing is deliverable.

Top module: `ic_irq_ctrl`

## Requirements
- R1: After reset every enable, pending, active, trigger-mode and priority bit is zero, the threshold (0x2004) is zero, the global enable (0x000 bit 0) is off, irq_out is low, and both the acknowledge (0x200C) and query (0x2018) registers read 1023.
- R2: Writing 1s to word w at 0x100+4w sets enable bits, and writing 1s at 0x180+4w clears them. ID n is bit n%32 of word n/32. Zero bits leave state unchanged. Reading either address returns the enable word.
- R3: The same mapping applies to pending state. 0x200+4w sets it, 0x280+4w clears it, and either address reads it back. Active state reads at 0x300+4w.
- R4: At 0xC00+4w a 1 bit makes the ID edge-triggered and a 0 bit makes it level-sensitive. Input line k drives ID 32+k.
- R5: The priority of ID n is byte n%4 of word 0x400+4(n/4). Only bits [7:4] of each byte are stored, and bits [3:0] read back as 0. A smaller value is more urgent.
- R6: Among IDs that are pending, enabled and not active, the winner has the smallest priority. Equal priorities go to the lowest ID.
- R7: The winner is deliverable only while the global enable is set and its 8-bit priority is strictly below the threshold. irq_out is high exactly while a deliverable winner exists.
- R8: A read of 0x2018 returns the deliverable winner's ID in bits [9:0], or 1023 when there is none, and changes no state.
- R9: A read of 0x200C returns the same value. When that value is a real ID, the ID becomes active and its pending bit clears. When it is 1023, no state changes.
- R10: While any ID is active, a candidate is deliverable only if its priority is strictly below the smallest priority among the active IDs.
- R11: A write of an ID in bits [9:0] to 0x2010 clears that ID's active bit and the running priority falls back to the remaining active IDs. IDs at or beyond the implemented count, including 1023, are ignored.
- R12: For an edge-triggered ID, a 0-to-1 transition of its input sets pending. An input held high does not set pending again.
- R13: For a level-sensitive ID, a high input sets pending while the ID is not active. After end-of-interrupt with the input still high, the ID pends again.
- R14: Read data appears on bus_rdata in the cycle after the request. Write effects appear from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_IRQ-FIRST_PERIPH | Peripheral request lines; line k drives ID FIRST_PERIPH+k |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a nested one. One ID must be active, a second ID of the same priority must be pending and held back, and a more urgent third ID must preempt both. Running priority must then fall back step by step as end-of-interrupt writes arrive. The bench builds this with a single priority word that sets four adjacent IDs to distinct and equal levels. It then interleaves set-pending writes, acknowledge reads and end-of-interrupt writes, and queries the winner after every step. Level re-pend after retirement is reached by holding a peripheral line high across the acknowledge and end-of-interrupt sequence and reading the pending bank between each step.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int ADDR_W = 14;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

    localparam logic [ADDR_W-1:0] A_CTRL  = 14'h0000;
    localparam logic [ADDR_W-1:0] A_SETEN = 14'h0100;
    localparam logic [ADDR_W-1:0] A_CLREN = 14'h0180;
    localparam logic [ADDR_W-1:0] A_SETPD = 14'h0200;
    localparam logic [ADDR_W-1:0] A_CLRPD = 14'h0280;
    localparam logic [ADDR_W-1:0] A_ACTV  = 14'h0300;
    localparam logic [ADDR_W-1:0] A_PRIO  = 14'h0400;
    localparam logic [ADDR_W-1:0] A_TRIG  = 14'h0C00;
    localparam logic [ADDR_W-1:0] A_MASK  = 14'h2004;
    localparam logic [ADDR_W-1:0] A_ACK   = 14'h200C;
    localparam logic [ADDR_W-1:0] A_EOI   = 14'h2010;
    localparam logic [ADDR_W-1:0] A_HPP   = 14'h2018;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int w);
        return base + ADDR_W'(w * 4);
    endfunction
endpackage

// File: rtl/ic_minfind.sv
module ic_minfind #(
    parameter int N    = 64,
    parameter int PW   = 4,
    parameter int IW   = $clog2(N)
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        pmin
);
    // Linear scan; strict compare keeps the lowest index on equal priority.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pmin  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || (prio[i] < pmin))) begin
                found = 1'b1;
                idx   = IW'(i);
                pmin  = prio[i];
            end
        end
    end
endmodule

// File: rtl/ic_srcdet.sv
module ic_srcdet #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] rise
);
    logic [NSRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src;
        rise   = src & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ic_irq_ctrl.sv
module ic_irq_ctrl
    import ic_pkg::*;
#(
    parameter int NUM_IRQ      = 64,
    parameter int FIRST_PERIPH = 32,
    parameter int PRIO_W       = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_IRQ-FIRST_PERIPH-1:0] irq_src,
    input  logic                            bus_sel,
    input  logic                            bus_we,
    input  logic [13:0]                     bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    output logic                            irq_out
);
    localparam int NSRC   = NUM_IRQ - FIRST_PERIPH;
    localparam int NWORDS = NUM_IRQ / 32;
    localparam int PWORDS = NUM_IRQ / 4;
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int PSHIFT = 8 - PRIO_W;

    typedef struct packed {
        logic                            gen;
        logic [7:0]                      mask;
        logic [NUM_IRQ-1:0]              en;
        logic [NUM_IRQ-1:0]              pend;
        logic [NUM_IRQ-1:0]              act;
        logic [NUM_IRQ-1:0]              trig_edge;
        logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio;
        logic [31:0]                     rdata;
    } state_t;

    state_t q, d;

    logic [NSRC-1:0]    src_rise;
    logic [NUM_IRQ-1:0] eligible;
    logic               sel_found, run_any;
    logic [IDX_W-1:0]   sel_idx, run_idx;
    logic [PRIO_W-1:0]  sel_prio, run_prio;
    logic               deliver;
    logic [ID_W-1:0]    win_id;
    logic               rd, wr, ack_rd, hpp_rd, eoi_wr;

    ic_srcdet #(.NSRC(NSRC)) u_srcdet (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (irq_src),
        .rise  (src_rise)
    );

    assign eligible = q.pend & q.en & ~q.act;

    ic_minfind #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_pick (
        .req   (eligible),
        .prio  (q.prio),
        .found (sel_found),
        .idx   (sel_idx),
        .pmin  (sel_prio)
    );

    ic_minfind #(.N(NUM_IRQ), .PW(PRIO_W), .IW(IDX_W)) u_running (
        .req   (q.act),
        .prio  (q.prio),
        .found (run_any),
        .idx   (run_idx),
        .pmin  (run_prio)
    );

    always_comb begin
        deliver = sel_found && q.gen
               && ((8'(sel_prio) << PSHIFT) < q.mask)
               && (!run_any || (sel_prio < run_prio));
        win_id  = deliver ? ID_W'(sel_idx) : NO_IRQ_ID;
    end

    assign rd     = bus_sel && !bus_we;
    assign wr     = bus_sel && bus_we;
    assign ack_rd = rd && (bus_addr == A_ACK);
    assign hpp_rd = rd && (bus_addr == A_HPP);
    assign eoi_wr = wr && (bus_addr == A_EOI);

    always_comb begin
        d = q;

        // Register reads, including the side-effecting acknowledge.
        if (rd) begin
            d.rdata = '0;
            if (bus_addr == A_CTRL) d.rdata[0] = q.gen;
            if (bus_addr == A_MASK) d.rdata[7:0] = q.mask;
            if (bus_addr == A_HPP || bus_addr == A_ACK) d.rdata[ID_W-1:0] = win_id;
            for (int w = 0; w < NWORDS; w++) begin
                if (bus_addr == word_addr(A_SETEN, w) || bus_addr == word_addr(A_CLREN, w))
                    d.rdata = q.en[w*32 +: 32];
                if (bus_addr == word_addr(A_SETPD, w) || bus_addr == word_addr(A_CLRPD, w))
                    d.rdata = q.pend[w*32 +: 32];
                if (bus_addr == word_addr(A_ACTV, w))
                    d.rdata = q.act[w*32 +: 32];
                if (bus_addr == word_addr(A_TRIG, w))
                    d.rdata = q.trig_edge[w*32 +: 32];
            end
            for (int w = 0; w < PWORDS; w++) begin
                if (bus_addr == word_addr(A_PRIO, w)) begin
                    for (int b = 0; b < 4; b++)
                        d.rdata[8*b+7 -: PRIO_W] = q.prio[4*w+b];
                end
            end
            if (ack_rd && deliver) begin
                d.act[sel_idx]  = 1'b1;
                d.pend[sel_idx] = 1'b0;
            end
        end

        // Register writes.
        if (wr) begin
            if (bus_addr == A_CTRL) d.gen = bus_wdata[0];
            if (bus_addr == A_MASK) d.mask = bus_wdata[7:0];
            for (int w = 0; w < NWORDS; w++) begin
                if (bus_addr == word_addr(A_SETEN, w)) d.en[w*32 +: 32]   = q.en[w*32 +: 32] | bus_wdata;
                if (bus_addr == word_addr(A_CLREN, w)) d.en[w*32 +: 32]   = q.en[w*32 +: 32] & ~bus_wdata;
                if (bus_addr == word_addr(A_SETPD, w)) d.pend[w*32 +: 32] = q.pend[w*32 +: 32] | bus_wdata;
                if (bus_addr == word_addr(A_CLRPD, w)) d.pend[w*32 +: 32] = q.pend[w*32 +: 32] & ~bus_wdata;
                if (bus_addr == word_addr(A_TRIG, w))  d.trig_edge[w*32 +: 32] = bus_wdata;
            end
            for (int w = 0; w < PWORDS; w++) begin
                if (bus_addr == word_addr(A_PRIO, w)) begin
                    for (int b = 0; b < 4; b++)
                        d.prio[4*w+b] = bus_wdata[8*b+7 -: PRIO_W];
                end
            end
            if (eoi_wr && (bus_wdata[ID_W-1:0] < ID_W'(NUM_IRQ)))
                d.act[bus_wdata[IDX_W-1:0]] = 1'b0;
        end

        // Peripheral inputs, applied after bus effects so a level line
        // sees the active state that results from this cycle.
        for (int k = 0; k < NSRC; k++) begin
            if (q.trig_edge[FIRST_PERIPH+k]) begin
                if (src_rise[k]) d.pend[FIRST_PERIPH+k] = 1'b1;
            end else if (irq_src[k] && !d.act[FIRST_PERIPH+k]) begin
                d.pend[FIRST_PERIPH+k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign irq_out   = deliver;

    // R9: a granted acknowledge leaves the winner active.
    a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && deliver) |=> q.act[$past(sel_idx)]);

    // R9: an acknowledge with nothing deliverable returns 1023 and changes no active state.
    a_r9_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !deliver) |=> (bus_rdata == 32'(NO_IRQ_ID)) && $stable(q.act));

    // R8: the query read leaves active state untouched.
    a_r8_query_pure: assert property (@(posedge clk) disable iff (!rst_n)
        hpp_rd |=> $stable(q.act));

    // R11: end-of-interrupt with an implemented ID retires it.
    a_r11_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && (bus_wdata[ID_W-1:0] < ID_W'(NUM_IRQ))) |=> !q.act[$past(bus_wdata[IDX_W-1:0])]);

    // R10: a nested grant always lowers the running priority value.
    a_r10_nest_deeper: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && deliver && run_any) |=> (run_prio < $past(run_prio)));

    // R10: the running priority belongs to an ID that is really active.
    a_r10_run_member: assert property (@(posedge clk) disable iff (!rst_n)
        run_any |-> q.act[run_idx]);
endmodule

// File: tb/ic_irq_ctrl_tb_top.sv
module ic_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0;
    int failed = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ic_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    function automatic logic [13:0] wa(input logic [13:0] base, input int id);
        return base + 14'((id / 32) * 4);
    endfunction

    function automatic logic [31:0] bt(input int id);
        return 32'h1 << (id % 32);
    endfunction

    task automatic pend(input int id);   wr(wa(14'h200, id), bt(id)); endtask
    task automatic unpend(input int id); wr(wa(14'h280, id), bt(id)); endtask
    task automatic enab(input int id);   wr(wa(14'h100, id), bt(id)); endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq_out", {31'b0, irq_out}, 0);
        rd(14'h200C, v); chk("R1 ack", v, 1023);
        rd(14'h2018, v); chk("R1 query", v, 1023);
        rd(14'h0100, v); chk("R1 enable", v, 0);
        rd(14'h0404, v); chk("R1 prio", v, 0);
        rd(14'h2004, v); chk("R1 mask", v, 0);
        rd(14'h0300, v); chk("R1 active", v, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(14'h0104, 32'h5);
        rd(14'h0184, v); chk("R2 set-enable word1", v, 32'h5);
        wr(14'h0184, 32'h1);
        rd(14'h0104, v); chk("R2 clear-enable", v, 32'h4);
        wr(14'h0104, 32'h0);
        rd(14'h0104, v); chk("R2 zero write no effect", v, 32'h4);
        rd(14'h0100, v); chk("R2 word0 untouched", v, 32'h0);
        wr(14'h0184, 32'hFFFF_FFFF);
    endtask

    task automatic t_prio_bits;
        logic [31:0] v;
        wr(14'h0404, 32'h4F3C_2A1F);
        rd(14'h0404, v); chk("R5 low nibble dropped", v, 32'h4030_2010);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        wr(14'h0000, 32'h1);
        wr(14'h2004, 32'hFF);
        enab(5); pend(5);
        chk("R7 irq_out raised", {31'b0, irq_out}, 1);
        rd(14'h0200, v); chk("R3 pending bit", v, bt(5));
        rd(14'h2018, v); chk("R8 query", v, 5);
        rd(14'h2018, v); chk("R8 query repeat", v, 5);
        chk("R8 irq still high", {31'b0, irq_out}, 1);
        rd(14'h200C, v); chk("R9 ack id", v, 5);
        chk("R9 irq drops", {31'b0, irq_out}, 0);
        rd(14'h0300, v); chk("R9 active", v, bt(5));
        rd(14'h0200, v); chk("R9 pending cleared", v, 0);
        wr(14'h2010, 32'd5);
        rd(14'h0300, v); chk("R11 retired", v, 0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(14'h2004, 32'h20);
        pend(5);
        chk("R7 equal mask blocks", {31'b0, irq_out}, 0);
        rd(14'h2018, v); chk("R7 query blocked", v, 1023);
        wr(14'h2004, 32'h21);
        chk("R7 below mask delivers", {31'b0, irq_out}, 1);
        wr(14'h0000, 32'h0);
        chk("R7 global off", {31'b0, irq_out}, 0);
        wr(14'h0000, 32'h1);
        unpend(5);
        chk("R3 clear-pending", {31'b0, irq_out}, 0);
        rd(14'h0280, v); chk("R3 pending read", v, 0);
        wr(14'h2004, 32'hFF);
        wr(14'h0180, 32'hFFFF_FFFF);
    endtask

    task automatic t_select;
        logic [31:0] v;
        enab(8); enab(9); enab(12);
        pend(2); pend(9); pend(12);
        rd(14'h2018, v); chk("R6 tie lowest enabled id", v, 9);
        wr(14'h0408, 32'h0000_5000);
        rd(14'h2018, v); chk("R6 smaller priority wins", v, 12);
        pend(8);
        rd(14'h2018, v); chk("R6 tie 8 vs 12", v, 8);
        wr(14'h0280, 32'hFFFF_FFFF);
        wr(14'h0180, 32'hFFFF_FFFF);
    endtask

    task automatic t_preempt;
        logic [31:0] v;
        wr(14'h0410, 32'h3020_4040);
        wr(14'h0100, 32'h000F_0000);
        pend(16);
        rd(14'h200C, v); chk("R9 ack 16", v, 16);
        pend(17);
        chk("R10 equal no preempt irq", {31'b0, irq_out}, 0);
        rd(14'h2018, v); chk("R10 equal no preempt", v, 1023);
        pend(18);
        rd(14'h2018, v); chk("R10 urgent preempts", v, 18);
        rd(14'h200C, v); chk("R10 ack nested", v, 18);
        pend(19);
        rd(14'h2018, v); chk("R10 blocked by nested", v, 1023);
        wr(14'h2010, 32'd18);
        rd(14'h2018, v); chk("R11 restore running prio", v, 19);
        unpend(19);
        rd(14'h2018, v); chk("R11 still under 16", v, 1023);
        wr(14'h2010, 32'd1023);
        rd(14'h0300, v); chk("R11 out of range ignored", v, bt(16));
        wr(14'h2010, 32'd16);
        rd(14'h2018, v); chk("R11 after final eoi", v, 17);
        rd(14'h200C, v);
        wr(14'h2010, 32'd17);
        wr(14'h0180, 32'hFFFF_FFFF);
    endtask

    task automatic t_spurious;
        logic [31:0] v;
        rd(14'h200C, v); chk("R9 spurious id", v, 1023);
        rd(14'h0300, v); chk("R9 spurious no change", v, 0);
        rd(14'h0304, v); chk("R9 spurious no change hi", v, 0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(14'h0C04, 32'h4);
        enab(34);
        rd(14'h0C04, v); chk("R4 trigger readback", v, 32'h4);
        @(negedge clk); irq_src[2] = 1'b1;
        rd(14'h0204, v); chk("R12 rise pends", v, 32'h4);
        chk("R12 irq", {31'b0, irq_out}, 1);
        rd(14'h200C, v); chk("R12 ack", v, 34);
        wr(14'h2010, 32'd34);
        repeat (3) @(negedge clk);
        rd(14'h0204, v); chk("R12 held high no re-pend", v, 0);
        chk("R12 irq low", {31'b0, irq_out}, 0);
        @(negedge clk); irq_src[2] = 1'b0;
        @(negedge clk); irq_src[2] = 1'b1;
        rd(14'h0204, v); chk("R12 second rise", v, 32'h4);
        irq_src[2] = 1'b0;
        unpend(34);
        wr(14'h0180, 32'hFFFF_FFFF);
        wr(14'h0184, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        logic [31:0] v;
        enab(35);
        @(negedge clk); irq_src[3] = 1'b1;
        rd(14'h0204, v); chk("R13 level pends", v, 32'h8);
        rd(14'h200C, v); chk("R13 ack", v, 35);
        rd(14'h0204, v); chk("R13 no pend while active", v, 0);
        wr(14'h2010, 32'd35);
        rd(14'h0204, v); chk("R13 re-pend after eoi", v, 32'h8);
        chk("R13 irq again", {31'b0, irq_out}, 1);
        @(negedge clk); irq_src[3] = 1'b0;
        unpend(35);
        rd(14'h0204, v); chk("R13 cleared after drop", v, 0);
        chk("R13 irq low", {31'b0, irq_out}, 0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 14'h0404;
        chk("R14 data not yet", bus_rdata, 32'h0000_0000);
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R14 data next cycle", bus_rdata, 32'h4030_2010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_prio_bits();
        t_basic();
        t_mask();
        t_select();
        t_preempt();
        t_spurious();
        t_edge();
        t_level();
        t_timing();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++; failed++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule